// File: doc/BRIEF.md
# Asynchronous FIFO Write Sequencer

This block runs from the system clock and drives the write side of an external FIFO whose port has no clock. It places the FIFO address, a chip select, the data byte, an active-low write strobe and an active-low packet-end strobe on the pins. Every setup, hold and pulse-width rule of that port is a parameter counted in clock cycles. The FIFO takes the byte on the rising edge of the write strobe.

The user side is a valid/ready command port. A WRITE command carries an address and a byte. A COMMIT command carries an address and pulses packet-end, which closes a short packet. A burst is a run of WRITE commands. Each byte goes through the full per-byte sequence, so a single write, a three-byte burst and a commit produce a four-byte short packet. Before each byte the sequencer reads the FIFO's active-low full flag through a two-stage synchronizer. It holds off while the flag shows full.

Top module: `sfifo_wr_master`

## Requirements
- R1: While reset is high and in the first cycle after it, the write strobe, packet-end strobe and chip select are high (inactive), and the command ready output is high.
- R2: The address and chip select (low) are driven and unchanged for at least T_ADDR_SU cycles before the write strobe falls, and the address does not change while the strobe is low.
- R3: The write strobe stays low for exactly max(T_WR_LO, T_DATA_SU) cycles.
- R4: The byte on the data bus at the rising edge of the write strobe equals the command's byte, and it has been stable since the strobe fell. It stays unchanged for at least T_DATA_HOLD cycles after the rise.
- R5: The address stays unchanged for at least T_ADDR_HOLD cycles after the write strobe rises.
- R6: Between a rise of the write strobe and its next fall, or the next fall of packet-end, the write strobe is high for at least T_WR_HI cycles.
- R7: Packet-end is never low while the write strobe is low. A COMMIT pulses packet-end low for exactly T_PE_LO cycles.
- R8: The address stays constant during the whole packet-end pulse and equals the COMMIT command's address.
- R9: While the synchronized full flag is low (full), no write strobe starts. After the flag goes high, the strobe falls exactly 2 + T_ADDR_SU cycles later.
- R10: A command is accepted when valid and ready are both high at a clock edge (cmd_kind 0 = WRITE, 1 = COMMIT). Ready is low from the next cycle until the sequence ends. This lasts 1 + T_ADDR_SU + max(T_WR_LO, T_DATA_SU) + max(T_WR_HI, T_DATA_HOLD, T_ADDR_HOLD) cycles for a WRITE with the FIFO not full, and T_ADDR_SU + T_PE_LO + T_PE_HI cycles for a COMMIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_kind | input | 1 | 0 = WRITE, 1 = COMMIT |
| cmd_addr | input | ADDR_W | FIFO address for the command |
| cmd_data | input | DATA_W | Byte for a WRITE |
| fifo_full_n | input | 1 | FIFO full flag, active low, asynchronous |
| fifo_addr | output | ADDR_W | FIFO address lines |
| fifo_cs_n | output | 1 | Chip select, active low |
| fifo_wr_n | output | 1 | Write strobe, active low |
| fifo_data | output | DATA_W | Data bus |
| fifo_pktend_n | output | 1 | Packet-end strobe, active low |

## Verification
All pin outputs are registered from the next-state decode, so each pin changes in the cycle the sequencer enters the matching phase. The busy time after an accepting edge is the sum of the phase lengths in R10. Pin timing is measured by a monitor that samples on the falling clock edge and counts whole cycles between strobe edges. Every width check is therefore an exact count of samples and needs no time window. The full-flag test releases the flag between edges and expects the strobe to fall at the sample that follows the two synchronizer stages plus the address setup phase.

// File: rtl/sfw_pkg.sv
package sfw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHK,
        ST_ASU,
        ST_WLO,
        ST_REC,
        ST_PSU,
        ST_PLO,
        ST_PHI
    } sfw_state_e;

    typedef enum logic {
        CMD_WRITE  = 1'b0,
        CMD_COMMIT = 1'b1
    } sfw_cmd_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sfw_flag_sync.sv
module sfw_flag_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], async_in};
    end

    assign sync_out = sh[STAGES-1];
endmodule

// File: rtl/sfw_interval_timer.sv
module sfw_interval_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sfifo_wr_master.sv
module sfifo_wr_master
    import sfw_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int DATA_W      = 8,
    parameter int T_ADDR_SU   = 2,
    parameter int T_WR_LO     = 3,
    parameter int T_DATA_SU   = 2,
    parameter int T_DATA_HOLD = 1,
    parameter int T_ADDR_HOLD = 2,
    parameter int T_WR_HI     = 2,
    parameter int T_PE_LO     = 3,
    parameter int T_PE_HI     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_kind,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              fifo_full_n,
    output logic [ADDR_W-1:0] fifo_addr,
    output logic              fifo_cs_n,
    output logic              fifo_wr_n,
    output logic [DATA_W-1:0] fifo_data,
    output logic              fifo_pktend_n
);
    localparam int LO_CYC  = max2(T_WR_LO, T_DATA_SU);
    localparam int REC_CYC = max2(T_WR_HI, max2(T_DATA_HOLD, T_ADDR_HOLD));
    localparam int MAX_T   = max2(max2(LO_CYC, REC_CYC),
                                  max2(T_ADDR_SU, max2(T_PE_LO, T_PE_HI)));
    localparam int CNT_W   = $clog2(MAX_T + 1);

    sfw_state_e        state, state_d;
    logic              tmr_load, tmr_exp, full_n_s;
    logic [CNT_W-1:0]  tmr_val;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              wr_n_q, cs_n_q, pe_n_q;

    sfw_flag_sync #(.STAGES(2)) u_full_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (fifo_full_n),
        .sync_out (full_n_s)
    );

    sfw_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    always_comb begin
        state_d  = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_IDLE: if (cmd_valid) begin
                if (sfw_cmd_e'(cmd_kind) == CMD_COMMIT) begin
                    state_d  = ST_PSU;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(T_ADDR_SU - 1);
                end else begin
                    state_d  = ST_CHK;
                end
            end
            ST_CHK: if (full_n_s) begin
                state_d  = ST_ASU;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(T_ADDR_SU - 1);
            end
            ST_ASU: if (tmr_exp) begin
                state_d  = ST_WLO;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(LO_CYC - 1);
            end
            ST_WLO: if (tmr_exp) begin
                state_d  = ST_REC;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(REC_CYC - 1);
            end
            ST_REC: if (tmr_exp) state_d = ST_IDLE;
            ST_PSU: if (tmr_exp) begin
                state_d  = ST_PLO;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(T_PE_LO - 1);
            end
            ST_PLO: if (tmr_exp) begin
                state_d  = ST_PHI;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(T_PE_HI - 1);
            end
            ST_PHI: if (tmr_exp) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            data_q <= '0;
            wr_n_q <= 1'b1;
            cs_n_q <= 1'b1;
            pe_n_q <= 1'b1;
        end else begin
            state <= state_d;
            if (state == ST_IDLE && cmd_valid) begin
                addr_q <= cmd_addr;
                data_q <= cmd_data;
            end
            wr_n_q <= (state_d != ST_WLO);
            pe_n_q <= (state_d != ST_PLO);
            cs_n_q <= !(state_d inside {ST_ASU, ST_WLO, ST_REC, ST_PSU, ST_PLO, ST_PHI});
        end
    end

    assign cmd_ready     = (state == ST_IDLE);
    assign fifo_addr     = addr_q;
    assign fifo_data     = data_q;
    assign fifo_wr_n     = wr_n_q;
    assign fifo_cs_n     = cs_n_q;
    assign fifo_pktend_n = pe_n_q;

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(!fifo_wr_n && !fifo_pktend_n)); // R7
    AST_CS_BEFORE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $fell(fifo_wr_n) |-> !$past(fifo_cs_n)); // R2
    AST_ADDR_HELD_STROBE: assert property (@(posedge clk) disable iff (rst)
        (!fifo_wr_n && !$past(fifo_wr_n)) |-> $stable(fifo_addr)); // R2
    AST_DATA_HELD_STROBE: assert property (@(posedge clk) disable iff (rst)
        (!fifo_wr_n && !$past(fifo_wr_n)) |-> $stable(fifo_data)); // R4
    AST_ADDR_HELD_PKTEND: assert property (@(posedge clk) disable iff (rst)
        (!fifo_pktend_n && !$past(fifo_pktend_n)) |-> $stable(fifo_addr)); // R8
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> !cmd_ready); // R10
    AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> (fifo_wr_n && fifo_pktend_n)); // R1
endmodule

// File: tb/sfifo_wr_master_bench.sv
module sfifo_wr_master_bench;
    localparam int AW = 2, DW = 8;
    localparam int T_ADDR_SU = 2, T_WR_LO = 3, T_DATA_SU = 2, T_DATA_HOLD = 1;
    localparam int T_ADDR_HOLD = 2, T_WR_HI = 2, T_PE_LO = 3, T_PE_HI = 2;
    localparam int LO_CYC  = 3;
    localparam int WR_BUSY = 1 + T_ADDR_SU + LO_CYC + 2;
    localparam int PE_BUSY = T_ADDR_SU + T_PE_LO + T_PE_HI;
    localparam int NV = 7;
    // vector: [10] commit, [9:8] addr, [7:0] data
    localparam logic [10:0] VEC [NV] = '{
        {1'b0, 2'd0, 8'h11}, {1'b0, 2'd0, 8'h22}, {1'b0, 2'd0, 8'h33},
        {1'b0, 2'd0, 8'h44}, {1'b1, 2'd0, 8'h00}, {1'b0, 2'd2, 8'hA5},
        {1'b1, 2'd2, 8'h00}};

    logic clk = 0, rst = 1;
    logic cmd_valid = 0, cmd_kind = 0, fifo_full_n = 1;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic cmd_ready, fifo_cs_n, fifo_wr_n, fifo_pktend_n;
    logic [AW-1:0] fifo_addr;
    logic [DW-1:0] fifo_data;
    int errors = 0, checks = 0;

    always #4 clk = ~clk;

    sfifo_wr_master u_sfifo_wr_master (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .fifo_full_n(fifo_full_n), .fifo_addr(fifo_addr), .fifo_cs_n(fifo_cs_n),
        .fifo_wr_n(fifo_wr_n), .fifo_data(fifo_data), .fifo_pktend_n(fifo_pktend_n));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // pin monitor, falling-edge samples
    logic prev_wr = 1, prev_pe = 1;
    logic [AW-1:0] prev_addr = '0, pe_addr = '0;
    logic [DW-1:0] prev_data = '0;
    int lo_cnt = 0, hi_cnt = 99, su_cnt = 0, pe_lo = 0, falls = 0;
    bit pe_addr_ok = 1;
    logic [DW-1:0] cap_data [16];
    logic [AW-1:0] cap_addr [16];
    logic [AW-1:0] pe_rec [8];
    int cap_n = 0, pe_n = 0;

    always @(negedge clk) if (!rst) begin
        if (prev_wr && !fifo_wr_n) begin
            falls++;
            check(su_cnt >= T_ADDR_SU, "R2 setup", su_cnt, T_ADDR_SU);
            check(hi_cnt >= T_WR_HI, "R6 high width", hi_cnt, T_WR_HI);
            lo_cnt = 1;
        end else if (!fifo_wr_n) begin
            lo_cnt++;
        end else if (!prev_wr && fifo_wr_n) begin
            check(lo_cnt == LO_CYC, "R3 low width", lo_cnt, LO_CYC);
            if (cap_n < 16) begin
                cap_data[cap_n] = prev_data;
                cap_addr[cap_n] = prev_addr;
                cap_n++;
            end
            hi_cnt = 1;
        end else begin
            hi_cnt++;
        end
        if (fifo_wr_n && cap_n > 0 && hi_cnt == T_ADDR_HOLD)
            check(fifo_addr == cap_addr[cap_n-1], "R5 addr hold", fifo_addr, cap_addr[cap_n-1]);
        if (fifo_wr_n && cap_n > 0 && hi_cnt == T_DATA_HOLD)
            check(fifo_data == cap_data[cap_n-1], "R4 data hold", fifo_data, cap_data[cap_n-1]);
        if (prev_pe && !fifo_pktend_n) begin
            check(fifo_wr_n == 1'b1, "R7 exclusive", fifo_wr_n, 1);
            check(hi_cnt >= T_WR_HI, "R6 before pktend", hi_cnt, T_WR_HI);
            pe_lo = 1; pe_addr = fifo_addr; pe_addr_ok = 1;
        end else if (!fifo_pktend_n) begin
            pe_lo++;
            if (fifo_addr != pe_addr) pe_addr_ok = 0;
        end else if (!prev_pe && fifo_pktend_n) begin
            check(pe_lo == T_PE_LO, "R7 pktend width", pe_lo, T_PE_LO);
            check(pe_addr_ok, "R8 addr during pktend", pe_addr_ok, 1);
            if (pe_n < 8) begin pe_rec[pe_n] = pe_addr; pe_n++; end
        end
        if (fifo_cs_n || fifo_addr != prev_addr) su_cnt = 0;
        else if (fifo_wr_n && fifo_pktend_n) su_cnt++;
        prev_wr = fifo_wr_n; prev_pe = fifo_pktend_n;
        prev_addr = fifo_addr; prev_data = fifo_data;
    end

    task automatic send(input logic kind, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, output int busy);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1; cmd_kind = kind; cmd_addr = a; cmd_data = d;
        @(posedge clk); #1 cmd_valid = 0;
        busy = 0;
        @(negedge clk);
        while (!cmd_ready && busy < 1000) begin busy++; @(negedge clk); end
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int busy;
        int exp_w;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 during reset
        check(fifo_wr_n && fifo_pktend_n && fifo_cs_n && cmd_ready, "R1 in reset",
              {fifo_wr_n, fifo_pktend_n, fifo_cs_n, cmd_ready}, 15);
        rst = 0;
        @(negedge clk);
        check(fifo_wr_n && fifo_pktend_n && fifo_cs_n && cmd_ready, "R1 after reset",
              {fifo_wr_n, fifo_pktend_n, fifo_cs_n, cmd_ready}, 15);
        repeat (3) @(negedge clk);

        exp_w = 0;
        for (int i = 0; i < NV; i++) begin
            send(VEC[i][10], VEC[i][9:8], VEC[i][7:0], busy);
            check(busy == (VEC[i][10] ? PE_BUSY : WR_BUSY), "R10 busy cycles",
                  busy, VEC[i][10] ? PE_BUSY : WR_BUSY);
        end
        repeat (4) @(negedge clk);
        // R4 captured bytes in order
        for (int i = 0; i < NV; i++) begin
            if (!VEC[i][10]) begin
                check(exp_w < cap_n && cap_data[exp_w] == VEC[i][7:0], "R4 captured byte",
                      cap_data[exp_w], VEC[i][7:0]);
                check(cap_addr[exp_w] == VEC[i][9:8], "R2 captured addr",
                      cap_addr[exp_w], VEC[i][9:8]);
                exp_w++;
            end
        end
        check(pe_n == 2 && pe_rec[0] == 2'd0 && pe_rec[1] == 2'd2, "R8 commit addr",
              pe_n, 2);

        // R9 stall while full, resume after sync + setup
        fifo_full_n = 0;
        repeat (4) @(negedge clk);
        begin
            int f0, waitc;
            f0 = falls;
            cmd_valid = 1; cmd_kind = 0; cmd_addr = 2'd1; cmd_data = 8'h5A;
            @(posedge clk); #1 cmd_valid = 0;
            repeat (20) @(negedge clk);
            check(falls == f0 && fifo_wr_n, "R9 no strobe while full", falls - f0, 0);
            check(!cmd_ready, "R10 ready low while stalled", cmd_ready, 0);
            fifo_full_n = 1;
            waitc = 0;
            @(negedge clk);
            while (fifo_wr_n && waitc < 50) begin waitc++; @(negedge clk); end
            check(waitc == 2 + T_ADDR_SU, "R9 resume delay", waitc, 2 + T_ADDR_SU);
            while (!cmd_ready) @(negedge clk);
            check(cap_n > 0 && cap_data[cap_n-1] == 8'h5A && cap_addr[cap_n-1] == 2'd1,
                  "R4 byte after stall", cap_data[cap_n-1], 8'h5A);
        end

        // R7 commit right after write, and R1 reset mid-sequence
        send(1'b0, 2'd3, 8'hC3, busy);
        send(1'b1, 2'd3, 8'h00, busy);
        check(busy == PE_BUSY, "R10 commit after write", busy, PE_BUSY);
        cmd_valid = 1; cmd_kind = 0; cmd_addr = 2'd2; cmd_data = 8'h77;
        @(posedge clk); #1 cmd_valid = 0;
        repeat (4) @(negedge clk);
        rst = 1;
        @(negedge clk);
        check(fifo_wr_n && fifo_cs_n && cmd_ready, "R1 reset mid write",
              {fifo_wr_n, fifo_cs_n, cmd_ready}, 7);
        rst = 0;
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule